// File: doc/BRIEF.md
# CAN Mailbox Transmit Request Controller

This block keeps the per-mailbox transmit bookkeeping for a small set of CAN mailboxes. Software raises transmit requests and cancel requests through a register write port. An abstract CAN bit engine takes the lowest-index eligible mailbox, reports the bus phase, and signals when a frame finishes or when a frame has been received into a mailbox. The block keeps four per-mailbox bit sets: pending, cancel, transmit acknowledge and abort acknowledge. It also keeps a receive-done bit set and a three-bit interrupt cause register. Each mailbox can be masked out of interrupt generation.

A cancel request for a mailbox that is waiting and not yet on the bus takes effect at once: the request is withdrawn and abort acknowledge is set. A frame that is already being sent is never cut short. If the cancel lands while the bus is at start-of-frame or in intermission, the frame still runs to completion. The block then reports both transmit acknowledge and abort acknowledge for that mailbox, and clears its pending and cancel bits. Asserting the standby input returns every register to its reset value, the same as reset does.

Top module: `can_mbx_txctl`

## Requirements
- R1: Writing 1s to address 0 sets pending bits. Writing 0s there clears nothing. A pending bit is cleared only by the block, when its frame completes or when it is cancelled. Address 0 reads the pending bits.
- R2: `tx_req_o` is high when some pending mailbox is neither cancelled nor in flight. `tx_sel_o` then gives the lowest such index. A pulse on `tx_start_i` puts that mailbox in flight.
- R3: Writing 1 at address 1 for a pending mailbox that is not in flight clears its pending bit and sets its abort acknowledge bit (address 3) within two cycles. The frame is not transmitted.
- R4: Writing 1 at address 1 for a mailbox with no pending request has no effect. Cancel bits (address 1) are never set without the matching pending bit.
- R5: The bus phase input is encoded 0 idle, 1 start-of-frame, 2 frame body, 3 intermission. A cancel for the in-flight mailbox written in phase 1 or 3, including in the same cycle as `tx_start_i`, lets the frame complete. On `tx_done_i` the block sets both transmit acknowledge (address 2) and abort acknowledge for it, and clears its pending and cancel bits.
- R6: A cancel for the in-flight mailbox written in the frame body is dropped at completion. Only transmit acknowledge is set.
- R7: Transmit acknowledge (2), abort acknowledge (3), receive done (4) and interrupt cause (6) are cleared by writing 1s. A hardware set in the same cycle wins over the clear.
- R8: The mask is written and read at address 5. For a masked mailbox, its receive-done, transmit-done and abort events set their status bits but raise no interrupt cause bit.
- R9: Cause bit 0 means receive done, bit 1 transmit done, bit 2 abort. `irq_o` is high exactly when some cause bit is set.
- R10: Reset or `standby_i` clears every register, including the in-flight state. `irq_o` and `tx_req_o` go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Standby entry; resets all registers |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | NUM_MB | Write data, one bit per mailbox |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | NUM_MB | Registered read data |
| phase_i | input | 2 | Bus phase from the bit engine |
| tx_start_i | input | 1 | Engine starts the frame of `tx_sel_o` |
| tx_done_i | input | 1 | In-flight frame completed |
| rx_done_i | input | 1 | Receive completed |
| rx_mb_i | input | IDX_W | Mailbox that received |
| tx_req_o | output | 1 | Some mailbox is eligible to send |
| tx_sel_o | output | IDX_W | Lowest eligible mailbox |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two things can fall in the same cycle: a cancel write and the start of that mailbox's frame. The bench provokes this by driving `tx_start_i` and the cancel write on one edge while the phase is intermission. It then judges that the frame is not withdrawn: pending stays set until `tx_done_i`, and both acknowledges appear afterwards. The same late-cancel outcome is checked for a cancel written one cycle after the start, at start-of-frame. A cancel written in the frame body must leave abort acknowledge clear.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;
  localparam int ADDR_W  = 3;
  localparam int CAUSE_W = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SOF  = 2'd1,
    PH_BODY = 2'd2,
    PH_IFS  = 2'd3
  } bus_phase_e;

  localparam logic [ADDR_W-1:0] A_PEND  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CANC  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TXACK = 3'd2;
  localparam logic [ADDR_W-1:0] A_ABORT = 3'd3;
  localparam logic [ADDR_W-1:0] A_RXD   = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CAUSE = 3'd6;

  localparam int CAUSE_RX = 0;
  localparam int CAUSE_TX = 1;
  localparam int CAUSE_AB = 2;
endpackage

// File: rtl/can_mbx_pick.sv
module can_mbx_pick #(
  parameter int NUM_MB = 8,
  parameter int IDX_W  = $clog2(NUM_MB)
) (
  input  logic [NUM_MB-1:0] req,
  output logic [IDX_W-1:0]  idx,
  output logic              any
);
  always_comb begin
    idx = '0;
    any = |req;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/can_mbx_regif.sv
module can_mbx_regif
  import can_mbx_pkg::*;
#(
  parameter int NUM_MB = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [NUM_MB-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [NUM_MB-1:0]   pend,
  input  logic [NUM_MB-1:0]   canc,
  input  logic [NUM_MB-1:0]   txack,
  input  logic [NUM_MB-1:0]   abort,
  input  logic [NUM_MB-1:0]   rxd,
  input  logic [NUM_MB-1:0]   mask,
  input  logic [CAUSE_W-1:0]  cause,
  output logic [NUM_MB-1:0]   set_pend,
  output logic [NUM_MB-1:0]   set_canc,
  output logic [NUM_MB-1:0]   clr_txack,
  output logic [NUM_MB-1:0]   clr_abort,
  output logic [NUM_MB-1:0]   clr_rxd,
  output logic                mask_we,
  output logic [NUM_MB-1:0]   mask_wdata,
  output logic [CAUSE_W-1:0]  clr_cause,
  output logic [NUM_MB-1:0]   rd_data
);
  function automatic logic [NUM_MB-1:0] hit(input logic [ADDR_W-1:0] a);
    return (wr_en && wr_addr == a) ? wr_data : '0;
  endfunction

  assign set_pend   = hit(A_PEND);
  assign set_canc   = hit(A_CANC);
  assign clr_txack  = hit(A_TXACK);
  assign clr_abort  = hit(A_ABORT);
  assign clr_rxd    = hit(A_RXD);
  assign mask_we    = wr_en && wr_addr == A_MASK;
  assign mask_wdata = wr_data;
  assign clr_cause  = (wr_en && wr_addr == A_CAUSE) ? wr_data[CAUSE_W-1:0] : '0;

  logic [NUM_MB-1:0] rd_mux;
  always_comb begin
    unique case (rd_addr)
      A_PEND:  rd_mux = pend;
      A_CANC:  rd_mux = canc;
      A_TXACK: rd_mux = txack;
      A_ABORT: rd_mux = abort;
      A_RXD:   rd_mux = rxd;
      A_MASK:  rd_mux = mask;
      A_CAUSE: rd_mux = NUM_MB'(cause);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/can_mbx_txstate.sv
module can_mbx_txstate
  import can_mbx_pkg::*;
#(
  parameter int NUM_MB = 8,
  parameter int IDX_W  = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_MB-1:0] set_pend,
  input  logic [NUM_MB-1:0] set_canc,
  input  logic [NUM_MB-1:0] clr_txack,
  input  logic [NUM_MB-1:0] clr_abort,
  input  logic [1:0]        phase,
  input  logic              tx_start,
  input  logic              tx_done,
  output logic [NUM_MB-1:0] pend_q,
  output logic [NUM_MB-1:0] canc_q,
  output logic [NUM_MB-1:0] txack_q,
  output logic [NUM_MB-1:0] abort_q,
  output logic              busy_q,
  output logic [IDX_W-1:0]  cur_q,
  output logic              late_q,
  output logic [NUM_MB-1:0] ev_tx,
  output logic [NUM_MB-1:0] ev_ab,
  output logic [IDX_W-1:0]  sel,
  output logic              req
);
  logic [NUM_MB-1:0] cur_oh, start_oh, done_oh, elig, canc_req, immed;
  logic [NUM_MB-1:0] pend_n, canc_n, txack_n, abort_n;
  logic              start_ok, done_ok, late_ph, late_hit, late_eff;

  assign cur_oh = busy_q ? (NUM_MB'(1) << cur_q) : '0;
  assign elig   = pend_q & ~canc_q & ~cur_oh;

  can_mbx_pick #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_pick (
    .req (elig),
    .idx (sel),
    .any (req)
  );

  assign start_ok = tx_start && !busy_q && req;
  assign start_oh = start_ok ? (NUM_MB'(1) << sel) : '0;
  assign done_ok  = tx_done && busy_q;
  assign done_oh  = done_ok ? cur_oh : '0;

  assign canc_req = set_canc & pend_q;
  assign late_ph  = (bus_phase_e'(phase) == PH_SOF) || (bus_phase_e'(phase) == PH_IFS);
  assign late_hit = late_ph && |(canc_req & (cur_oh | start_oh));
  assign late_eff = late_q | late_hit;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    assign immed[i]   = canc_q[i] & ~cur_oh[i];
    assign pend_n[i]  = set_pend[i] | (pend_q[i] & ~done_oh[i] & ~immed[i]);
    assign canc_n[i]  = ~done_oh[i] & ~immed[i] & (canc_q[i] | canc_req[i]);
    assign ev_tx[i]   = done_oh[i];
    assign ev_ab[i]   = immed[i] | (done_oh[i] & late_eff);
    assign txack_n[i] = ev_tx[i] | (txack_q[i] & ~clr_txack[i]);
    assign abort_n[i] = ev_ab[i] | (abort_q[i] & ~clr_abort[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      canc_q  <= '0;
      txack_q <= '0;
      abort_q <= '0;
      busy_q  <= 1'b0;
      cur_q   <= '0;
      late_q  <= 1'b0;
    end else begin
      pend_q  <= pend_n;
      canc_q  <= canc_n;
      txack_q <= txack_n;
      abort_q <= abort_n;
      if (start_ok) begin
        busy_q <= 1'b1;
        cur_q  <= sel;
        late_q <= late_hit;
      end else if (done_ok) begin
        busy_q <= 1'b0;
        late_q <= 1'b0;
      end else begin
        late_q <= late_eff;
      end
    end
  end
endmodule

// File: rtl/can_mbx_irq.sv
module can_mbx_irq
  import can_mbx_pkg::*;
#(
  parameter int NUM_MB = 8,
  parameter int IDX_W  = $clog2(NUM_MB)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_done,
  input  logic [IDX_W-1:0]   rx_mb,
  input  logic [NUM_MB-1:0]  clr_rxd,
  input  logic [CAUSE_W-1:0] clr_cause,
  input  logic               mask_we,
  input  logic [NUM_MB-1:0]  mask_wdata,
  input  logic [NUM_MB-1:0]  ev_tx,
  input  logic [NUM_MB-1:0]  ev_ab,
  output logic [NUM_MB-1:0]  rxd_q,
  output logic [NUM_MB-1:0]  mask_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               irq_q
);
  logic [NUM_MB-1:0]  rx_oh;
  logic [CAUSE_W-1:0] raise, cause_n;

  assign rx_oh = (rx_done && int'(rx_mb) < NUM_MB) ? (NUM_MB'(1) << rx_mb) : '0;

  always_comb begin
    raise           = '0;
    raise[CAUSE_RX] = |(rx_oh & ~mask_q);
    raise[CAUSE_TX] = |(ev_tx & ~mask_q);
    raise[CAUSE_AB] = |(ev_ab & ~mask_q);
  end

  assign cause_n = raise | (cause_q & ~clr_cause);

  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_q   <= '0;
      mask_q  <= '0;
      cause_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rxd_q   <= rx_oh | (rxd_q & ~clr_rxd);
      if (mask_we) mask_q <= mask_wdata;
      cause_q <= cause_n;
      irq_q   <= |cause_n;
    end
  end
endmodule

// File: rtl/can_mbx_txctl.sv
module can_mbx_txctl
  import can_mbx_pkg::*;
#(
  parameter int NUM_MB = 8,
  parameter int IDX_W  = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [NUM_MB-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [NUM_MB-1:0] rd_data_o,
  input  logic [1:0]        phase_i,
  input  logic              tx_start_i,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  input  logic [IDX_W-1:0]  rx_mb_i,
  output logic              tx_req_o,
  output logic [IDX_W-1:0]  tx_sel_o,
  output logic              irq_o
);
  logic               rst_all;
  logic [NUM_MB-1:0]  pend_w, canc_w, txack_w, abort_w, rxd_w, mask_w;
  logic [NUM_MB-1:0]  set_pend_w, set_canc_w, clr_txack_w, clr_abort_w, clr_rxd_w;
  logic [NUM_MB-1:0]  mask_wdata_w, ev_tx_w, ev_ab_w;
  logic [CAUSE_W-1:0] cause_w, clr_cause_w;
  logic               mask_we_w, busy_w, late_w;
  logic [IDX_W-1:0]   cur_w;

  assign rst_all = rst | standby_i;

  can_mbx_regif #(.NUM_MB(NUM_MB)) u_regif (
    .clk        (clk),
    .rst        (rst_all),
    .wr_en      (wr_en_i),
    .wr_addr    (wr_addr_i),
    .wr_data    (wr_data_i),
    .rd_addr    (rd_addr_i),
    .pend       (pend_w),
    .canc       (canc_w),
    .txack      (txack_w),
    .abort      (abort_w),
    .rxd        (rxd_w),
    .mask       (mask_w),
    .cause      (cause_w),
    .set_pend   (set_pend_w),
    .set_canc   (set_canc_w),
    .clr_txack  (clr_txack_w),
    .clr_abort  (clr_abort_w),
    .clr_rxd    (clr_rxd_w),
    .mask_we    (mask_we_w),
    .mask_wdata (mask_wdata_w),
    .clr_cause  (clr_cause_w),
    .rd_data    (rd_data_o)
  );

  can_mbx_txstate #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_tx (
    .clk       (clk),
    .rst       (rst_all),
    .set_pend  (set_pend_w),
    .set_canc  (set_canc_w),
    .clr_txack (clr_txack_w),
    .clr_abort (clr_abort_w),
    .phase     (phase_i),
    .tx_start  (tx_start_i),
    .tx_done   (tx_done_i),
    .pend_q    (pend_w),
    .canc_q    (canc_w),
    .txack_q   (txack_w),
    .abort_q   (abort_w),
    .busy_q    (busy_w),
    .cur_q     (cur_w),
    .late_q    (late_w),
    .ev_tx     (ev_tx_w),
    .ev_ab     (ev_ab_w),
    .sel       (tx_sel_o),
    .req       (tx_req_o)
  );

  can_mbx_irq #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_irq (
    .clk        (clk),
    .rst        (rst_all),
    .rx_done    (rx_done_i),
    .rx_mb      (rx_mb_i),
    .clr_rxd    (clr_rxd_w),
    .clr_cause  (clr_cause_w),
    .mask_we    (mask_we_w),
    .mask_wdata (mask_wdata_w),
    .ev_tx      (ev_tx_w),
    .ev_ab      (ev_ab_w),
    .rxd_q      (rxd_w),
    .mask_q     (mask_w),
    .cause_q    (cause_w),
    .irq_q      (irq_o)
  );
endmodule

// File: rtl/can_mbx_txctl_chk.sv
module can_mbx_txctl_chk
  import can_mbx_pkg::*;
#(
  parameter int NUM_MB = 8,
  parameter int IDX_W  = $clog2(NUM_MB)
) (
  input logic               clk,
  input logic               rst,
  input logic               standby_i,
  input logic               wr_en_i,
  input logic [2:0]         wr_addr_i,
  input logic [NUM_MB-1:0]  wr_data_i,
  input logic               tx_done_i,
  input logic               rx_done_i,
  input logic [IDX_W-1:0]   rx_mb_i,
  input logic               tx_req_o,
  input logic [IDX_W-1:0]   tx_sel_o,
  input logic               irq_o,
  input logic [NUM_MB-1:0]  pend,
  input logic [NUM_MB-1:0]  canc,
  input logic [NUM_MB-1:0]  txack,
  input logic [NUM_MB-1:0]  abort,
  input logic [NUM_MB-1:0]  mask,
  input logic [CAUSE_W-1:0] cause,
  input logic               busy,
  input logic [IDX_W-1:0]   cur,
  input logic               late
);
  // R4
  canc_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (canc & ~pend) == '0);

  // R4
  canc_no_new_chk: assert property (@(posedge clk) disable iff (rst || standby_i)
    (wr_en_i && wr_addr_i == A_CANC && (wr_data_i & pend) == '0)
    |=> (canc & ~$past(canc)) == '0);

  // R1
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst || standby_i)
    (!(tx_done_i && busy) && canc == '0 && !(wr_en_i && wr_addr_i == A_PEND))
    |=> pend == $past(pend));

  // R5
  late_both_chk: assert property (@(posedge clk) disable iff (rst || standby_i)
    (tx_done_i && busy && late)
    |=> txack[$past(cur)] && abort[$past(cur)]);

  // R2
  sel_valid_chk: assert property (@(posedge clk) disable iff (rst)
    tx_req_o |-> (pend[tx_sel_o] && !canc[tx_sel_o]));

  // R10
  standby_clear_chk: assert property (@(posedge clk) disable iff (rst)
    standby_i |=> (pend == '0 && cause == '0 && !irq_o && !busy));

  // R8
  mask_rx_chk: assert property (@(posedge clk) disable iff (rst || standby_i)
    (rx_done_i && mask[rx_mb_i] && !cause[CAUSE_RX]) |=> !cause[CAUSE_RX]);

  // R9
  irq_or_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|cause));
endmodule

bind can_mbx_txctl can_mbx_txctl_chk #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .standby_i (standby_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .tx_done_i (tx_done_i),
  .rx_done_i (rx_done_i),
  .rx_mb_i   (rx_mb_i),
  .tx_req_o  (tx_req_o),
  .tx_sel_o  (tx_sel_o),
  .irq_o     (irq_o),
  .pend      (pend_w),
  .canc      (canc_w),
  .txack     (txack_w),
  .abort     (abort_w),
  .mask      (mask_w),
  .cause     (cause_w),
  .busy      (busy_w),
  .cur       (cur_w),
  .late      (late_w)
);

// File: tb/tb_can_mbx_txctl.sv
`timescale 1ns/1ps
module tb_can_mbx_txctl;
  import can_mbx_pkg::*;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          standby_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [2:0]    wr_addr_i = '0;
  logic [N-1:0]  wr_data_i = '0;
  logic [2:0]    rd_addr_i = '0;
  logic [N-1:0]  rd_data_o;
  logic [1:0]    phase_i = 2'd0;
  logic          tx_start_i = 1'b0;
  logic          tx_done_i = 1'b0;
  logic          rx_done_i = 1'b0;
  logic [IW-1:0] rx_mb_i = '0;
  logic          tx_req_o;
  logic [IW-1:0] tx_sel_o;
  logic          irq_o;

  always #4 clk = ~clk;

  can_mbx_txctl #(.NUM_MB(N)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    rd_addr_i = a;
    @(negedge clk);
    v = rd_data_o;
  endtask

  task automatic rdchk(input string tag, input logic [2:0] a, input logic [N-1:0] exp);
    logic [N-1:0] v;
    rd(a, v);
    chk(tag, 32'(v), 32'(exp));
  endtask

  task automatic pulse_done();
    @(negedge clk); phase_i = 2'd2; tx_done_i = 1'b1;
    @(negedge clk); tx_done_i = 1'b0; phase_i = 2'd3;
  endtask

  task automatic start_frame();
    @(negedge clk); phase_i = 2'd1; tx_start_i = 1'b1;
    @(negedge clk); tx_start_i = 1'b0;
  endtask

  // {write addr, write data, read addr, expected}
  localparam int NV = 7;
  localparam logic [21:0] VEC [NV] = '{
    {A_MASK,  8'h00, A_MASK,  8'h00},  // R8 mask write/read
    {A_PEND,  8'h05, A_PEND,  8'h05},  // R1 set pending
    {A_PEND,  8'h00, A_PEND,  8'h05},  // R1 zeros clear nothing
    {A_CANC,  8'h02, A_CANC,  8'h00},  // R4 cancel of idle mailbox ignored
    {A_CANC,  8'h04, A_ABORT, 8'h04},  // R3 immediate cancel sets abort
    {A_ABORT, 8'h04, A_ABORT, 8'h00},  // R7 abort cleared by write-1
    {A_TXACK, 8'hFF, A_PEND,  8'h01}   // R3 pending withdrawn for mailbox 2
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R10 reset state
    for (int a = 0; a < 7; a++) rdchk("R10 reset reg", 3'(a), '0);
    chk("R10 reset irq", 32'(irq_o), 0);
    chk("R10 reset tx_req", 32'(tx_req_o), 0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0]   va, vra;
      logic [N-1:0] vd, vexp;
      {va, vd, vra, vexp} = VEC[i];
      wr(va, vd);
      idle(2);
      rdchk($sformatf("vector %0d", i), vra, vexp);
    end
    // R2 lowest index selection
    chk("R2 tx_req", 32'(tx_req_o), 1);
    chk("R2 sel lowest", 32'(tx_sel_o), 0);
    wr(A_PEND, 8'h30);
    chk("R2 sel still 0", 32'(tx_sel_o), 0);

    // R5 late cancel at start-of-frame
    start_frame();
    chk("R2 in-flight excluded", 32'(tx_sel_o), 4);
    phase_i = 2'd1;
    wr(A_CANC, 8'h01);
    phase_i = 2'd2;
    idle(2);
    rdchk("R5 pending held in flight", A_PEND, 8'h31);
    rdchk("R5 no ack before done", A_TXACK, 8'h00);
    pulse_done();
    idle(1);
    rdchk("R5 txack set", A_TXACK, 8'h01);
    rdchk("R5 abort set", A_ABORT, 8'h01);
    rdchk("R5 pending cleared", A_PEND, 8'h30);
    rdchk("R5 cancel cleared", A_CANC, 8'h00);
    rdchk("R9 cause tx+abort", A_CAUSE, 8'h06);
    chk("R9 irq high", 32'(irq_o), 1);

    // R6 cancel during frame body
    start_frame();
    phase_i = 2'd2;
    wr(A_CANC, 8'h10);
    pulse_done();
    idle(1);
    rdchk("R6 txack only", A_TXACK, 8'h11);
    rdchk("R6 abort unchanged", A_ABORT, 8'h01);
    rdchk("R6 pending", A_PEND, 8'h20);

    // R7 cause clear, R8 masking
    wr(A_CAUSE, 8'h07);
    idle(1);
    rdchk("R7 cause cleared", A_CAUSE, 8'h00);
    chk("R9 irq low", 32'(irq_o), 0);
    wr(A_MASK, 8'h20);
    start_frame();
    pulse_done();
    idle(1);
    rdchk("R8 masked txack", A_TXACK, 8'h31);
    rdchk("R8 masked no cause", A_CAUSE, 8'h00);
    @(negedge clk); rx_done_i = 1'b1; rx_mb_i = 3'd5;
    @(negedge clk); rx_done_i = 1'b0;
    rdchk("R8 masked rx status", A_RXD, 8'h20);
    rdchk("R8 masked rx no cause", A_CAUSE, 8'h00);
    chk("R8 irq low", 32'(irq_o), 0);
    @(negedge clk); rx_done_i = 1'b1; rx_mb_i = 3'd3;
    @(negedge clk); rx_done_i = 1'b0;
    rdchk("R9 rx cause", A_CAUSE, 8'h01);
    chk("R9 irq rx", 32'(irq_o), 1);
    wr(A_RXD, 8'h08);
    idle(1);
    rdchk("R7 rxd w1c", A_RXD, 8'h20);

    // R5 cancel on the same edge as start, in intermission
    wr(A_PEND, 8'h04);
    chk("R2 sel 2", 32'(tx_sel_o), 2);
    @(negedge clk);
    phase_i = 2'd3; tx_start_i = 1'b1;
    wr_en_i = 1'b1; wr_addr_i = A_CANC; wr_data_i = 8'h04;
    @(negedge clk);
    tx_start_i = 1'b0; wr_en_i = 1'b0; phase_i = 2'd2;
    idle(2);
    rdchk("R5 same-edge pending held", A_PEND, 8'h04);
    pulse_done();
    idle(1);
    rdchk("R5 same-edge txack", A_TXACK, 8'h35);
    rdchk("R5 same-edge abort", A_ABORT, 8'h05);
    rdchk("R5 same-edge pending", A_PEND, 8'h00);

    // R10 standby clears everything
    wr(A_PEND, 8'h81);
    @(negedge clk); standby_i = 1'b1;
    @(negedge clk); standby_i = 1'b0;
    for (int a = 0; a < 7; a++) rdchk("R10 standby reg", 3'(a), '0);
    chk("R10 standby irq", 32'(irq_o), 0);
    chk("R10 standby tx_req", 32'(tx_req_o), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule